// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast reference clock into the 16x oversampling tick that a UART's receive and transmit shifters step on. The divide ratio is a 16-bit whole-number divisor, supplied as a high byte and a low byte, plus a 6-bit fraction counted in sixty-fourths of a clock. The required ratio is the reference frequency divided by sixteen times the baud rate. For example, a 24 MHz reference at 9600 baud needs 156.25. That value is programmed as high byte 0x00, low byte 0x9C and fraction 0x10.

A 64-state phase accumulator adds the fraction once per tick. Each time it wraps, the next tick period is one clock longer. The average period therefore equals the programmed ratio, while every single period is either the whole divisor or one more. A load strobe stages a new divisor. The staged value replaces the running one at the next tick boundary, or at once if the generator is idle, and the accumulator restarts from zero at that point.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, and after it falls until a divisor has been loaded, `tick` stays low. Reset leaves the running divisor at zero.
- R2: The whole divisor is `{div_hi, div_lo}` (high byte in bits 15:8). Every tick period, counted in clocks from one tick to the next, is either that divisor or that divisor plus one.
- R3: The accumulator adds `div_frac` at each tick boundary, modulo 64. A wrap stretches the following period by exactly one clock. `tick` matches a cycle-exact model of this schedule on every clock.
- R4: Over any 64 consecutive tick periods, excluding the first period after a divisor takes effect, the total clock count is 64 x divisor + fraction.
- R5: With a fraction of zero, every tick period is exactly the whole divisor.
- R6: A running divisor of zero produces no ticks.
- R7: A divisor of one with a zero fraction asserts `tick` on every clock.
- R8: A divisor captured by `div_load` replaces the running one at the next tick boundary, so the current period finishes at its old length. If the running divisor is zero, the replacement happens on the following clock. The accumulator and any pending stretch are cleared when the replacement happens.
- R9: For a divisor of two or more, `tick` is high for exactly one clock per period.
- R10: A divisor of 156 with a fraction of 16 gives 10000 clocks over 64 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_load | input | 1 | Stages the divisor inputs in the cycle it is high |
| div_hi | input | 8 | High byte of the whole divisor |
| div_lo | input | 8 | Low byte of the whole divisor |
| div_frac | input | 6 | Fraction in sixty-fourths |
| tick | output | 1 | One-clock pulse at 16x the baud rate |

## Verification
The generator is tried with a zero fraction, an odd fraction (23/64), a mid-range fraction (16/64, as in the 9600-baud case) and the largest fraction (63/64) on a large divisor. These patterns separate an exact integer divider from one that miscounts its wraps, stretches the wrong period or drops the carry. Divisors of one and zero probe the edges of the period counter. Loads made partway through a period show whether the old period is allowed to finish and whether the accumulator restarts from zero. Throughout, a behavioural model predicts `tick` on every clock.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
    // Default geometry: two divisor bytes and a fraction in 1/64 steps.
    localparam int unsigned DIV_BYTE_W_DEF = 8;
    localparam int unsigned DIV_FRAC_W_DEF = 6;
    localparam int unsigned DIV_BYTES      = 2;
endpackage

// File: rtl/frac_baud_shadow.sv
// Holds the running divisor and a staged one; swaps at a period boundary.
module frac_baud_shadow #(
    parameter int unsigned INT_W  = 16,
    parameter int unsigned FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [INT_W-1:0]  new_int,
    input  logic [FRAC_W-1:0] new_frac,
    input  logic              boundary,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic              apply
);
    typedef struct packed {
        logic [INT_W-1:0]  run_int;
        logic [FRAC_W-1:0] run_frac;
        logic [INT_W-1:0]  stg_int;
        logic [FRAC_W-1:0] stg_frac;
        logic              stg_vld;
    } shadow_t;

    shadow_t st_d, st_q;
    logic    apply_c;

    always_comb begin
        st_d    = st_q;
        apply_c = st_q.stg_vld && (boundary || (st_q.run_int == '0));
        if (apply_c) begin
            st_d.run_int  = st_q.stg_int;
            st_d.run_frac = st_q.stg_frac;
            st_d.stg_vld  = 1'b0;
        end
        if (load) begin
            st_d.stg_int  = new_int;
            st_d.stg_frac = new_frac;
            st_d.stg_vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_int  = st_q.run_int;
    assign act_frac = st_q.run_frac;
    assign apply    = apply_c;
endmodule

// File: rtl/frac_baud_dither.sv
// Phase accumulator: a carry out of the fraction sum lengthens the next period.
module frac_baud_dither #(
    parameter int unsigned FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FRAC_W-1:0] frac,
    input  logic              boundary,
    input  logic              apply,
    output logic [FRAC_W-1:0] acc,
    output logic              stretch
);
    typedef struct packed {
        logic [FRAC_W-1:0] phase;
        logic              extra;
    } dither_t;

    dither_t      dt_d, dt_q;
    logic [FRAC_W:0] sum_c;

    always_comb begin
        dt_d  = dt_q;
        sum_c = {1'b0, dt_q.phase} + {1'b0, frac};
        if (apply) begin
            dt_d.phase = '0;
            dt_d.extra = 1'b0;
        end else if (boundary) begin
            dt_d.phase = sum_c[FRAC_W-1:0];
            dt_d.extra = sum_c[FRAC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dt_q <= '0;
        end else begin
            dt_q <= dt_d;
        end
    end

    assign acc     = dt_q.phase;
    assign stretch = dt_q.extra;
endmodule

// File: rtl/frac_baud_counter.sv
// Counts clocks within a period of (divisor + stretch) and emits the tick.
module frac_baud_counter #(
    parameter int unsigned INT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INT_W-1:0] act_int,
    input  logic             stretch,
    output logic             boundary,
    output logic [INT_W:0]   cnt,
    output logic             tick
);
    localparam int unsigned CW = INT_W + 1;

    typedef struct packed {
        logic [CW-1:0] count;
        logic          pulse;
    } ctr_t;

    ctr_t          ct_d, ct_q;
    logic [CW-1:0] len_c;
    logic          idle_c;
    logic          end_c;

    always_comb begin
        ct_d   = ct_q;
        idle_c = (act_int == '0);
        len_c  = {1'b0, act_int} + CW'(stretch);
        end_c  = !idle_c && ((ct_q.count + CW'(1)) == len_c);
        ct_d.pulse = end_c;
        if (end_c || idle_c) begin
            ct_d.count = '0;
        end else begin
            ct_d.count = ct_q.count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign boundary = end_c;
    assign cnt      = ct_q.count;
    assign tick     = ct_q.pulse;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int unsigned BYTE_W = DIV_BYTE_W_DEF,
    parameter int unsigned FRAC_W = DIV_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              div_load,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    localparam int unsigned INT_W = DIV_BYTES * BYTE_W;

    logic [INT_W-1:0]  new_int;
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic [FRAC_W-1:0] acc;
    logic [INT_W:0]    cnt;
    logic              apply;
    logic              boundary;
    logic              stretch;

    assign new_int = {div_hi, div_lo};

    frac_baud_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .new_int  (new_int),
        .new_frac (div_frac),
        .boundary (boundary),
        .act_int  (act_int),
        .act_frac (act_frac),
        .apply    (apply)
    );

    frac_baud_dither #(.FRAC_W(FRAC_W)) u_dither (
        .clk      (clk),
        .rst      (rst),
        .frac     (act_frac),
        .boundary (boundary),
        .apply    (apply),
        .acc      (acc),
        .stretch  (stretch)
    );

    frac_baud_counter #(.INT_W(INT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .act_int  (act_int),
        .stretch  (stretch),
        .boundary (boundary),
        .cnt      (cnt),
        .tick     (tick)
    );
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
    parameter int unsigned INT_W  = 16,
    parameter int unsigned FRAC_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              boundary,
    input logic              apply,
    input logic              stretch,
    input logic [INT_W-1:0]  act_int,
    input logic [FRAC_W-1:0] act_frac,
    input logic [FRAC_W-1:0] acc,
    input logic [INT_W:0]    cnt
);
    logic [FRAC_W:0] phase_sum;
    assign phase_sum = {1'b0, acc} + {1'b0, act_frac};

    // R6
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (act_int == '0) |=> !tick);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (act_int >= INT_W'(2))) |-> !boundary);

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (act_int != '0) |-> (cnt <= {1'b0, act_int}));

    // R8
    load_clear_chk: assert property (@(posedge clk) disable iff (rst)
        apply |=> ((acc == '0) && !stretch));

    // R3
    wrap_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && !apply && phase_sum[FRAC_W]) |=> stretch);

    // R7
    unit_div_chk: assert property (@(posedge clk) disable iff (rst)
        ((act_int == INT_W'(1)) && !stretch) |=> tick);
endmodule

bind frac_baud_gen frac_baud_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .boundary (boundary),
    .apply    (apply),
    .stretch  (stretch),
    .act_int  (act_int),
    .act_frac (act_frac),
    .acc      (acc),
    .cnt      (cnt)
);

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_load = 1'b0;
    logic [7:0] div_hi = '0;
    logic [7:0] div_lo = '0;
    logic [5:0] div_frac = '0;
    logic       tick;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    frac_baud_gen dut (
        .clk(clk), .rst(rst), .div_load(div_load),
        .div_hi(div_hi), .div_lo(div_lo), .div_frac(div_frac), .tick(tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Behavioural model: period length held as a number, phase as an integer mod 64.
    int m_div = 0, m_fr = 0, m_phase = 0, m_len = 0, m_seen = 0;
    int m_sdiv = 0, m_sfr = 0;
    bit m_staged = 0, m_exp = 0, m_en = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_fr = 0; m_phase = 0; m_len = 0; m_seen = 0;
            m_staged = 0; m_exp = 0;
        end else begin
            bit ends;
            ends = (m_div != 0) && (m_seen + 1 == m_len);
            if (ends) begin
                m_seen = 0;
                m_phase = m_phase + m_fr;
                m_len = m_div + ((m_phase >= 64) ? 1 : 0);
                m_phase = m_phase % 64;
            end else if (m_div != 0) begin
                m_seen++;
            end
            if (m_staged && (ends || m_div == 0)) begin
                m_div = m_sdiv; m_fr = m_sfr; m_phase = 0; m_len = m_sdiv;
                m_seen = 0; m_staged = 0;
            end
            if (div_load) begin
                m_staged = 1; m_sdiv = {div_hi, div_lo}; m_sfr = int'(div_frac);
            end
            m_exp = ends;
        end
    end

    // R3: cycle-exact comparison of tick against the model
    always @(negedge clk) begin
        if (m_en && !rst) check(tick == m_exp, "R3", int'(tick), int'(m_exp));
    end

    task automatic load(input int d, input int f);
        @(negedge clk);
        div_hi = 8'(d >> 8); div_lo = 8'(d); div_frac = 6'(f); div_load = 1'b1;
        @(negedge clk);
        div_load = 1'b0;
    endtask

    task automatic wait_tick(output int n, input string req);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 70000);
        if (!tick) check(1'b0, req, n, -1);
    endtask

    task automatic measure(input int d, input int f, input string req_sum);
        int n, sum;
        load(d, f);
        repeat (3) wait_tick(n, "R2");
        sum = 0;
        for (int i = 0; i < 64; i++) begin
            wait_tick(n, "R2");
            check(n == d || n == d + 1, "R2", n, d);
            if (f == 0) check(n == d, "R5", n, d);
            sum += n;
        end
        check(sum == 64 * d + f, req_sum, sum, 64 * d + f);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int n, cnt;
        // R1: reset and idle after reset
        repeat (4) @(negedge clk);
        check(tick == 1'b0, "R1", int'(tick), 0);
        rst = 1'b0;
        m_en = 1;
        cnt = 0;
        repeat (50) begin @(negedge clk); if (tick) cnt++; end
        check(cnt == 0, "R1", cnt, 0);

        // R5, R4: integer-only divisor
        measure(5, 0, "R4");
        // R9: pulse width one clock for divisor >= 2
        wait_tick(n, "R9");
        @(negedge clk);
        check(tick == 1'b0, "R9", int'(tick), 0);

        // R2, R4: odd fraction
        measure(7, 23, "R4");
        // R10: 24 MHz / 9600 baud setting
        measure(156, 16, "R10");
        // R4: largest fraction
        measure(300, 63, "R4");

        // R8: load mid-period, old period finishes
        load(10, 0);
        repeat (3) wait_tick(n, "R8");
        repeat (3) @(negedge clk);
        load(3, 0);
        wait_tick(n, "R8");
        check(n == 5, "R8", n, 5);
        wait_tick(n, "R8");
        check(n == 3, "R8", n, 3);

        // R8: accumulator restarts from zero on reload
        load(6, 40);
        repeat (5) wait_tick(n, "R8");
        @(negedge clk);
        load(6, 40);
        wait_tick(n, "R8");
        wait_tick(n, "R8"); check(n == 6, "R8", n, 6);
        wait_tick(n, "R8"); check(n == 6, "R8", n, 6);
        wait_tick(n, "R8"); check(n == 7, "R8", n, 7);

        // R7: divisor one, no fraction
        load(1, 0);
        repeat (3) wait_tick(n, "R7");
        cnt = 0;
        repeat (20) begin @(negedge clk); if (tick) cnt++; end
        check(cnt == 20, "R7", cnt, 20);

        // R6: divisor zero stops ticks
        load(4, 0);
        repeat (3) wait_tick(n, "R6");
        load(0, 0);
        wait_tick(n, "R6");
        cnt = 0;
        repeat (300) begin @(negedge clk); if (tick) cnt++; end
        check(cnt == 0, "R6", cnt, 0);

        // R8: from idle the new divisor applies on the next clock
        load(4, 0);
        wait_tick(n, "R8");
        check(n == 5, "R8", n, 5);

        summary();
    end
endmodule